// File: doc/BRIEF.md
# Status Register and Write Permission Unit

This block keeps the status byte of a serial non-volatile memory and decides, cycle by cycle, whether a pending array write or status write may go ahead. The byte holds a lock-enable bit, a two-bit protection zone code, the write enable latch and a write-in-progress flag. A command decoder upstream sends one-cycle strobes for the enable, disable and status-write commands. It also supplies the target address of a pending array write. The block answers with two permission flags and the byte to shift out on a status read.

The protection zone code fences off none, the top quarter, the top half or all of the array. A hardware lock pin works together with the lock-enable bit. When the bit is set and the pin is low, status writes are refused. The enable and disable commands still act in that state. While the external write engine reports busy, both permissions are withheld. When busy ends, the enable latch clears by itself.

Top module: `wprot_status_unit`

## Requirements
- R1: After reset with `wr_busy` low the status byte reads 0x00, and both permission outputs are 0.
- R2: The status byte is: bit 7 lock-enable, bits 6..4 always 0, bit 3 zone high bit, bit 2 zone low bit, bit 1 enable latch, and bit 0 equal to `wr_busy` in the same cycle.
- R3: A `cmd_wel_set` strobe sets the enable latch at the next clock edge. A `cmd_wel_clr` strobe clears it. When both arrive in the same cycle, the latch ends up cleared.
- R4: The enable latch clears at the first clock edge after `wr_busy` falls, even if `cmd_wel_set` is present in that cycle.
- R5: `arr_wr_ok` is 1 only when the latch is 1, `wr_busy` is 0 and `arr_addr` lies outside the protected zone. For the default 11-bit address, zone code 00 protects nothing, 01 protects 0x600..0x7FF, 10 protects 0x400..0x7FF and 11 protects 0x000..0x7FF.
- R6: `stat_wr_ok` is 1 only when the latch is 1, `wr_busy` is 0, and the lock is not active. The lock is active when lock-enable is 1 and `lock_pin_n` is 0.
- R7: A `cmd_stat_wr` strobe while `stat_wr_ok` is 1 loads bits 7, 3 and 2 of `stat_wdata` into lock-enable and the zone code at the next edge. Bits 6..4, 1 and 0 of `stat_wdata` are ignored. A strobe while `stat_wr_ok` is 0 changes nothing.
- R8: `cmd_wel_set` and `cmd_wel_clr` act whatever the lock state and whatever the level of `wr_busy`, except for the precedence given in R4.
- R9: A change on `lock_pin_n` never alters the stored lock-enable or zone bits. Only the permission it gates is affected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_wel_set | input | 1 | Enable command strobe (sent only after a complete instruction) |
| cmd_wel_clr | input | 1 | Disable command strobe |
| cmd_stat_wr | input | 1 | Status-write commit strobe |
| stat_wdata | input | 8 | Byte carried by the status write |
| arr_addr | input | ADDR_W (11) | Target address of the pending array write |
| lock_pin_n | input | 1 | Hardware lock pin; low requests the lock |
| wr_busy | input | 1 | Internal write cycle in progress |
| status_byte | output | 8 | Status byte for reads |
| arr_wr_ok | output | 1 | Array write to `arr_addr` permitted |
| stat_wr_ok | output | 1 | Status write permitted |

## Verification
The bench probes each zone code at the addresses just below and at the start of its fence. A decode that is off by one line, or that uses the wrong address bits, therefore flips a permission at exactly one of those points. It tries status writes with the pin low and lock-enable set, and then checks that the stored bits are unchanged. It also checks that enable and disable still work in that state, because a design that gates every write with the lock would freeze the latch. Other cases cover set and clear arriving together, and enable arriving in the cycle busy falls. The bench also writes status data with the unused and read-only bits set, so a design that stores them would show non-zero bits where zeros belong.

// File: rtl/wps_pkg.sv
package wps_pkg;

   // Field positions inside the status byte
   localparam int unsigned STB_LOCK_EN = 7;
   localparam int unsigned STB_ZONE_HI = 3;
   localparam int unsigned STB_ZONE_LO = 2;
   localparam int unsigned STB_WEL     = 1;
   localparam int unsigned STB_BUSY    = 0;

   typedef enum logic [1:0] {
      ZONE_NONE    = 2'b00,
      ZONE_QUARTER = 2'b01,
      ZONE_HALF    = 2'b10,
      ZONE_ALL     = 2'b11
   } zone_e;

   typedef struct packed {
      logic  lock_en;
      zone_e zone;
   } nv_cfg_t;

endpackage

// File: rtl/wps_zone_decode.sv
module wps_zone_decode
   import wps_pkg::*;
#(
   parameter int unsigned ADDR_W = 11
) (
   input  zone_e             zone,
   input  logic [ADDR_W-1:0] addr,
   output logic              in_zone
);
   localparam int unsigned TOP_BITS = 2;

   initial begin
      if (ADDR_W < TOP_BITS)
         $error("wps_zone_decode: ADDR_W must be at least %0d", TOP_BITS);
   end

   logic [TOP_BITS-1:0] top;
   assign top = addr[ADDR_W-1 -: TOP_BITS];

   always_comb begin
      unique case (zone)
         ZONE_NONE:    in_zone = 1'b0;
         ZONE_QUARTER: in_zone = &top;
         ZONE_HALF:    in_zone = top[TOP_BITS-1];
         default:      in_zone = 1'b1;
      endcase
   end
endmodule

// File: rtl/wps_wel_ctrl.sv
module wps_wel_ctrl (
   input  logic clk,
   input  logic rst_n,
   input  logic set_req,
   input  logic clr_req,
   input  logic busy,
   output logic wel
);
   logic busy_q;
   logic busy_done;

   assign busy_done = busy_q & ~busy;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         wel    <= 1'b0;
      end else begin
         busy_q <= busy;
         if (clr_req || busy_done)
            wel <= 1'b0;
         else if (set_req)
            wel <= 1'b1;
      end
   end
endmodule

// File: rtl/wps_nv_reg.sv
module wps_nv_reg
   import wps_pkg::*;
#(
   parameter logic [2:0] NV_INIT = 3'b000
) (
   input  logic    clk,
   input  logic    rst_n,
   input  logic    load,
   input  logic [7:0] wdata,
   output nv_cfg_t cfg
);
   localparam nv_cfg_t CFG_INIT = nv_cfg_t'(NV_INIT);

   nv_cfg_t cfg_next;
   assign cfg_next = '{lock_en: wdata[STB_LOCK_EN],
                       zone:    zone_e'(wdata[STB_ZONE_HI:STB_ZONE_LO])};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cfg <= CFG_INIT;
      else if (load)
         cfg <= cfg_next;
   end
endmodule

// File: rtl/wprot_status_unit.sv
module wprot_status_unit
   import wps_pkg::*;
#(
   parameter int unsigned ADDR_W  = 11,
   parameter logic [2:0]  NV_INIT = 3'b000,
   parameter bit          HOLD_ON_BUSY = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_wel_set,
   input  logic              cmd_wel_clr,
   input  logic              cmd_stat_wr,
   input  logic [7:0]        stat_wdata,
   input  logic [ADDR_W-1:0] arr_addr,
   input  logic              lock_pin_n,
   input  logic              wr_busy,
   output logic [7:0]        status_byte,
   output logic              arr_wr_ok,
   output logic              stat_wr_ok
);
   nv_cfg_t cfg;
   logic    wel;
   logic    in_zone;
   logic    hw_lock;
   logic    gate_ok;

   wps_wel_ctrl u_wel (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_req (cmd_wel_set),
      .clr_req (cmd_wel_clr),
      .busy    (wr_busy),
      .wel     (wel)
   );

   wps_zone_decode #(.ADDR_W(ADDR_W)) u_zone (
      .zone    (cfg.zone),
      .addr    (arr_addr),
      .in_zone (in_zone)
   );

   generate
      if (HOLD_ON_BUSY) begin : g_busy_gate
         assign gate_ok = wel & ~wr_busy;
      end else begin : g_no_busy_gate
         assign gate_ok = wel;
      end
   endgenerate

   assign hw_lock    = cfg.lock_en & ~lock_pin_n;
   assign arr_wr_ok  = gate_ok & ~in_zone;
   assign stat_wr_ok = gate_ok & ~hw_lock;

   wps_nv_reg #(.NV_INIT(NV_INIT)) u_nv (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (cmd_stat_wr & stat_wr_ok),
      .wdata (stat_wdata),
      .cfg   (cfg)
   );

   always_comb begin
      status_byte = 8'h00;
      status_byte[STB_LOCK_EN] = cfg.lock_en;
      status_byte[STB_ZONE_HI:STB_ZONE_LO] = cfg.zone;
      status_byte[STB_WEL]  = wel;
      status_byte[STB_BUSY] = wr_busy;
   end
endmodule

// File: rtl/wprot_status_unit_chk.sv
module wprot_status_unit_chk #(
   parameter int unsigned ADDR_W = 11
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cmd_wel_set,
   input logic              cmd_wel_clr,
   input logic              cmd_stat_wr,
   input logic              lock_pin_n,
   input logic              wr_busy,
   input logic [7:0]        status_byte,
   input logic              arr_wr_ok,
   input logic              stat_wr_ok
);
   // R2
   unused_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      status_byte[6:4] == 3'b000);

   // R2
   busy_mirror_chk: assert property (@(posedge clk) disable iff (!rst_n)
      status_byte[0] == wr_busy);

   // R3
   wel_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_wel_set && !cmd_wel_clr && !$fell(wr_busy)) |=> status_byte[1]);

   // R3
   wel_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_wel_clr |=> !status_byte[1]);

   // R4
   busy_end_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(wr_busy) |=> !status_byte[1]);

   // R5
   arr_needs_wel_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!status_byte[1] || wr_busy) |-> !arr_wr_ok);

   // R6
   lock_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (status_byte[7] && !lock_pin_n) |-> !stat_wr_ok);

   // R7
   nv_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(cmd_stat_wr && stat_wr_ok) |=> $stable({status_byte[7], status_byte[3:2]}));
endmodule

bind wprot_status_unit wprot_status_unit_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .cmd_wel_set (cmd_wel_set),
   .cmd_wel_clr (cmd_wel_clr),
   .cmd_stat_wr (cmd_stat_wr),
   .lock_pin_n  (lock_pin_n),
   .wr_busy     (wr_busy),
   .status_byte (status_byte),
   .arr_wr_ok   (arr_wr_ok),
   .stat_wr_ok  (stat_wr_ok)
);

// File: tb/wprot_status_unit_tb_top.sv
module wprot_status_unit_tb_top;
   localparam int unsigned ADDR_W = 11;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              cmd_wel_set = 1'b0;
   logic              cmd_wel_clr = 1'b0;
   logic              cmd_stat_wr = 1'b0;
   logic [7:0]        stat_wdata = 8'h00;
   logic [ADDR_W-1:0] arr_addr = '0;
   logic              lock_pin_n = 1'b1;
   logic              wr_busy = 1'b0;
   logic [7:0]        status_byte;
   logic              arr_wr_ok;
   logic              stat_wr_ok;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   wprot_status_unit #(.ADDR_W(ADDR_W)) dut_i (
      .clk(clk), .rst_n(rst_n),
      .cmd_wel_set(cmd_wel_set), .cmd_wel_clr(cmd_wel_clr),
      .cmd_stat_wr(cmd_stat_wr), .stat_wdata(stat_wdata),
      .arr_addr(arr_addr), .lock_pin_n(lock_pin_n), .wr_busy(wr_busy),
      .status_byte(status_byte), .arr_wr_ok(arr_wr_ok), .stat_wr_ok(stat_wr_ok)
   );

   task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %02h expected %02h", req, act, exp);
      end
   endtask

   // one-cycle strobes, driven after a falling edge, released after the rising edge
   task automatic pulse(input bit set, input bit clr, input bit swr, input logic [7:0] d);
      @(negedge clk);
      cmd_wel_set = set; cmd_wel_clr = clr; cmd_stat_wr = swr; stat_wdata = d;
      @(posedge clk); #1;
      cmd_wel_set = 1'b0; cmd_wel_clr = 1'b0; cmd_stat_wr = 1'b0;
   endtask

   task automatic probe(input string req, input logic [ADDR_W-1:0] a, input bit exp);
      @(negedge clk); arr_addr = a; #1;
      check(req, {7'd0, arr_wr_ok}, {7'd0, exp});
   endtask

   task automatic t_reset;
      check("R1 status", status_byte, 8'h00);
      check("R1 arr_ok", {7'd0, arr_wr_ok}, 8'h00);
      check("R1 stat_ok", {7'd0, stat_wr_ok}, 8'h00);
   endtask

   task automatic t_layout;
      @(negedge clk); wr_busy = 1'b1; #1;
      check("R2 busy bit", status_byte, 8'h01);
      @(negedge clk); wr_busy = 1'b0; #1;
      check("R2 busy low", status_byte, 8'h00);
   endtask

   task automatic t_wel;
      pulse(1, 0, 0, 8'h00);
      check("R3 set", status_byte, 8'h02);
      pulse(0, 1, 0, 8'h00);
      check("R3 clear", status_byte, 8'h00);
      pulse(1, 0, 0, 8'h00);
      pulse(1, 1, 0, 8'h00);
      check("R3 both clears", status_byte, 8'h00);
      // R7: status write without the latch is refused
      pulse(0, 0, 1, 8'h8C);
      check("R7 no latch", status_byte, 8'h00);
   endtask

   task automatic t_zones;
      lock_pin_n = 1'b1;
      pulse(1, 0, 0, 8'h00);
      pulse(0, 0, 1, 8'h73);   // unused and read-only bits only
      check("R7 ignored bits", status_byte, 8'h02);
      probe("R5 none 7FF", 11'h7FF, 1'b1);
      pulse(0, 0, 1, 8'h04);
      check("R7 zone 01", status_byte, 8'h06);
      probe("R5 quarter 5FF", 11'h5FF, 1'b1);
      probe("R5 quarter 600", 11'h600, 1'b0);
      pulse(0, 0, 1, 8'h08);
      check("R7 zone 10", status_byte, 8'h0A);
      probe("R5 half 3FF", 11'h3FF, 1'b1);
      probe("R5 half 400", 11'h400, 1'b0);
      pulse(0, 0, 1, 8'h0C);
      probe("R5 all 000", 11'h000, 1'b0);
      pulse(0, 0, 1, 8'h00);
      check("R7 zone 00", status_byte, 8'h02);
      probe("R5 none 000", 11'h000, 1'b1);
   endtask

   task automatic t_lock;
      pulse(0, 0, 1, 8'h80);
      check("R7 lock_en", status_byte, 8'h82);
      @(negedge clk); lock_pin_n = 1'b0; #1;
      check("R6 locked", {7'd0, stat_wr_ok}, 8'h00);
      check("R9 pin no store", status_byte, 8'h82);
      pulse(0, 0, 1, 8'h0C);
      check("R7 locked write", status_byte, 8'h82);
      pulse(0, 1, 0, 8'h00);
      check("R8 clr under lock", status_byte, 8'h80);
      pulse(1, 0, 0, 8'h00);
      check("R8 set under lock", status_byte, 8'h82);
      @(negedge clk); lock_pin_n = 1'b1; #1;
      check("R6 pin high", {7'd0, stat_wr_ok}, 8'h01);
      pulse(0, 0, 1, 8'h00);
      check("R7 unlock", status_byte, 8'h02);
      @(negedge clk); lock_pin_n = 1'b0; #1;
      check("R6 lock_en 0", {7'd0, stat_wr_ok}, 8'h01);
      lock_pin_n = 1'b1;
   endtask

   task automatic t_busy;
      @(negedge clk); wr_busy = 1'b1; arr_addr = 11'h000; #1;
      check("R5 busy arr", {7'd0, arr_wr_ok}, 8'h00);
      check("R6 busy stat", {7'd0, stat_wr_ok}, 8'h00);
      pulse(0, 0, 1, 8'h8C);
      check("R7 busy write", status_byte, 8'h03);
      @(negedge clk); lock_pin_n = 1'b0;
      @(negedge clk); lock_pin_n = 1'b1; #1;
      check("R9 pin toggle", status_byte, 8'h03);
      pulse(0, 1, 0, 8'h00);
      check("R8 clr busy", status_byte, 8'h01);
      pulse(1, 0, 0, 8'h00);
      check("R8 set busy", status_byte, 8'h03);
      @(negedge clk); wr_busy = 1'b0; #1;
      check("R2 busy fell", status_byte, 8'h02);
      @(posedge clk); #1;
      check("R4 auto clear", status_byte, 8'h00);
      // R4: set in the same cycle that busy falls loses
      pulse(1, 0, 0, 8'h00);
      @(negedge clk); wr_busy = 1'b1;
      @(negedge clk); wr_busy = 1'b0; cmd_wel_set = 1'b1;
      @(posedge clk); #1; cmd_wel_set = 1'b0;
      check("R4 set loses", status_byte, 8'h00);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1 t_reset();
      @(negedge clk); rst_n = 1'b1;
      t_reset();
      t_layout();
      t_wel();
      t_zones();
      t_lock();
      t_busy();
      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (20000) @(posedge clk);
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
         end
      join_any
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule